// File: doc/BRIEF.md
# Flash Access Protection Gate

This block sits between bus masters and a flash array controller and rules on every read, program and erase request before the array sees it. While reset is held, it takes in two values from option storage. One is a 16-bit security code, which gives one of three protection levels. The other is a 32-bit page-region write-protect mask. It keeps both values until the next reset. It also combines the current boot source with the debugger-attach status to decide whether the requester runs in a restricted context.

A granted request goes on to the flash controller as a one-cycle grant. A refused read comes back as a bus error. A refused program or erase sets a sticky write-protect error flag, and that flag can raise an interrupt. Two option-block operations get special handling. Lowering the security from the low level back to open first sends out a mass-erase request, and the originating request waits until the controller reports the erase done. An erase of the option block removes all page write protection at once.

Every accepted request is answered by exactly one acknowledge pulse. A new request is taken only while `req_ready` is high.

Top module: `flash_guard`

## Requirements
- R1: During reset the level is decoded from `opt_sec_code`. The value 16'h5AA5 gives open (`sec_level`=0). A low byte of 8'hCC gives high (`sec_level`=2). Every other value, including 16'h00A5, gives low (`sec_level`=1).
- R2: After reset is released, `sec_level` and the write-protect mask ignore changes on `opt_sec_code` and `opt_wp_mask` until the next reset.
- R3: At the open level, every main-flash request that hits no protected region is granted. This holds in every boot mode and with the debugger attached. A grant is `flash_gnt` and `req_ack` high together, one cycle after acceptance.
- R4: At the low level, in a restricted context, a main-flash read (`req_op`=0) is answered with `bus_err` and `req_ack` and no grant. A restricted context is `dbg_attached`=1 or `boot_mode`≠0, where 1 is SRAM boot and 2 is loader boot.
- R5: At the low level, in a restricted context, a main-flash program (`req_op`=1) or erase (`req_op`=2 or 3) is refused with `req_ack` only, and `wperr` is set.
- R6: Mask bit i covers main-flash pages whose top five page bits equal i. For 9-bit pages that means page>>4. A program or erase to a covered page is refused and sets `wperr` when that bit is 0.
- R7: `wperr` stays high until a cycle with `wperr_clr`=1 and no new error. `irq` equals `wperr` AND `err_ie`.
- R8: An erase of the option block (`req_opt`=1, `req_op`≠0,1) is granted. From then until reset the mask is treated as all ones.
- R9: At the low level, a program of the security field (`req_opt`=1, `req_sec_field`=1) with data 16'h5AA5 drives `mass_erase_req` high for exactly one cycle after acceptance. `req_ready` stays low, and no `req_ack` or `flash_gnt` is given, until the cycle after `mass_erase_done` is sampled high.
- R10: At the high level, a program of the security field is refused and sets `wperr`. In a restricted context, every request is refused: reads of either block with `bus_err`, and modifications by setting `wperr`.
- R11: At the low level, in a restricted context, option-block reads and programs are still granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; option values are taken in while high |
| opt_sec_code | input | 16 | Security code from option storage |
| opt_wp_mask | input | 32 | Region write-protect mask from option storage, 0 = protected |
| boot_mode | input | 2 | 0 main flash, 1 SRAM, 2 loader, 3 restricted |
| dbg_attached | input | 1 | Debugger connected |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_op | input | 2 | 0 read, 1 program, 2/3 erase |
| req_opt | input | 1 | 1 = option block target, 0 = main flash |
| req_sec_field | input | 1 | Option program targets the security field |
| req_page | input | 9 | Main-flash page index |
| req_wdata | input | 16 | Program data for option fields |
| req_ready | output | 1 | Gate idle, can accept a request |
| flash_gnt | output | 1 | One-cycle grant to the flash controller |
| req_ack | output | 1 | One-cycle completion acknowledge |
| bus_err | output | 1 | Refused read, with `req_ack` |
| mass_erase_req | output | 1 | One-cycle mass-erase request |
| mass_erase_done | input | 1 | Mass erase finished |
| wperr | output | 1 | Sticky write-protect error |
| wperr_clr | input | 1 | Clear for `wperr` (write-one) |
| err_ie | input | 1 | Error interrupt enable |
| irq | output | 1 | Operation-error interrupt |
| sec_level | output | 2 | Captured protection level |

## Verification
The bench targets the edges of the level decode. The value 16'h00A5 must decode as low; a design that checked only the low byte would report open. It also changes the option inputs after reset, which catches a design that decodes live values. Region checks use pages on both sides of a region boundary (15/16, 31/32), so an off-by-one region index shows up as a wrong grant. The mass-erase sequence is held for several cycles before the done input is given, which exposes an early acknowledge or a repeated erase pulse. The error flag is watched across unrelated cycles and with the interrupt enable both on and off, so a flag that self-clears, or an interrupt not masked by the enable, is reported.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2
  } sec_lvl_e;

  typedef enum logic [1:0] {
    DEC_GRANT  = 2'd0,
    DEC_BUSERR = 2'd1,
    DEC_WPERR  = 2'd2,
    DEC_RELAX  = 2'd3
  } gate_dec_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ERASE = 1'b1
  } gate_st_e;

  localparam logic [15:0] SEC_OPEN_CODE = 16'h5AA5;
  localparam logic [7:0]  SEC_HIGH_BYTE = 8'hCC;
endpackage

// File: rtl/fg_level_decode.sv
module fg_level_decode
  import flash_guard_pkg::*;
(
  input  logic [15:0] code,
  output sec_lvl_e    lvl
);
  always_comb begin
    if (code == SEC_OPEN_CODE)
      lvl = LVL_OPEN;
    else if (code[7:0] == SEC_HIGH_BYTE)
      lvl = LVL_HIGH;
    else
      lvl = LVL_LOW;
  end
endmodule

// File: rtl/fg_policy.sv
module fg_policy
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W  = 9,
  parameter int N_REG   = 32,
  parameter int DATA_W  = 16
) (
  input  sec_lvl_e          lvl,
  input  logic              restricted,
  input  logic [1:0]        op,
  input  logic              opt,
  input  logic              sec_field,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGE_W-1:0] page,
  input  logic [N_REG-1:0]  wp_live,
  output gate_dec_e         dec,
  output logic              wp_clear
);
  localparam int REG_W = $clog2(N_REG);

  logic [REG_W-1:0] region;
  logic             is_read;
  logic             is_prog;

  assign region  = page[PAGE_W-1 -: REG_W];
  assign is_read = (op == 2'd0);
  assign is_prog = (op == 2'd1);

  always_comb begin
    dec      = DEC_GRANT;
    wp_clear = 1'b0;
    if (restricted && lvl == LVL_HIGH) begin
      dec = is_read ? DEC_BUSERR : DEC_WPERR;
    end else if (!opt) begin
      if (restricted && lvl == LVL_LOW)
        dec = is_read ? DEC_BUSERR : DEC_WPERR;
      else if (!is_read && !wp_live[region])
        dec = DEC_WPERR;
    end else begin
      if (is_prog && sec_field) begin
        if (lvl == LVL_HIGH)
          dec = DEC_WPERR;
        else if (lvl == LVL_LOW && wdata == SEC_OPEN_CODE[DATA_W-1:0])
          dec = DEC_RELAX;
      end else if (!is_read && !is_prog) begin
        wp_clear = 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int N_REG  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       opt_sec_code,
  input  logic [N_REG-1:0]  opt_wp_mask,
  input  logic [1:0]        boot_mode,
  input  logic              dbg_attached,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_opt,
  input  logic              req_sec_field,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              flash_gnt,
  output logic              req_ack,
  output logic              bus_err,
  output logic              mass_erase_req,
  input  logic              mass_erase_done,
  output logic              wperr,
  input  logic              wperr_clr,
  input  logic              err_ie,
  output logic              irq,
  output logic [1:0]        sec_level
);
  sec_lvl_e         lvl_dec, lvl_q;
  logic [N_REG-1:0] wp_q;
  gate_st_e         st_q;
  gate_dec_e        dec;
  logic             wp_clear;
  logic             restricted;
  logic             accept;
  logic             wperr_set;
  logic             gnt_q, ack_q, berr_q, me_q, wperr_q;

  assign restricted = dbg_attached || (boot_mode != 2'd0);
  assign accept     = req_valid && (st_q == ST_IDLE);
  assign wperr_set  = accept && (dec == DEC_WPERR);

  fg_level_decode u_lvl (
    .code (opt_sec_code),
    .lvl  (lvl_dec)
  );

  fg_policy #(.PAGE_W(PAGE_W), .N_REG(N_REG), .DATA_W(DATA_W)) u_pol (
    .lvl        (lvl_q),
    .restricted (restricted),
    .op         (req_op),
    .opt        (req_opt),
    .sec_field  (req_sec_field),
    .wdata      (req_wdata),
    .page       (req_page),
    .wp_live    (wp_q),
    .dec        (dec),
    .wp_clear   (wp_clear)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= lvl_dec;
      wp_q    <= opt_wp_mask;
      st_q    <= ST_IDLE;
      gnt_q   <= 1'b0;
      ack_q   <= 1'b0;
      berr_q  <= 1'b0;
      me_q    <= 1'b0;
      wperr_q <= 1'b0;
    end else begin
      gnt_q  <= 1'b0;
      ack_q  <= 1'b0;
      berr_q <= 1'b0;
      me_q   <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          case (dec)
            DEC_GRANT: begin
              gnt_q <= 1'b1;
              ack_q <= 1'b1;
              if (wp_clear) wp_q <= '1;
            end
            DEC_BUSERR: begin
              berr_q <= 1'b1;
              ack_q  <= 1'b1;
            end
            DEC_WPERR: ack_q <= 1'b1;
            DEC_RELAX: begin
              me_q <= 1'b1;
              st_q <= ST_ERASE;
            end
            default: ack_q <= 1'b1;
          endcase
        end
        ST_ERASE: if (mass_erase_done) begin
          gnt_q <= 1'b1;
          ack_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (wperr_set)
        wperr_q <= 1'b1;
      else if (wperr_clr)
        wperr_q <= 1'b0;
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign flash_gnt      = gnt_q;
  assign req_ack        = ack_q;
  assign bus_err        = berr_q;
  assign mass_erase_req = me_q;
  assign wperr          = wperr_q;
  assign irq            = wperr_q & err_ie;
  assign sec_level      = lvl_q;

  // R2
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(lvl_q));

  // R4
  buserr_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
    berr_q |-> (ack_q && !gnt_q));

  // R7
  wperr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wperr_q && !wperr_clr) |=> wperr_q);

  // R9
  erase_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    me_q |=> !me_q);

  // R9
  erase_hold_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ERASE && !mass_erase_done) |=> !ack_q);

  // R10
  high_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == LVL_HIGH && restricted && accept) |=> !gnt_q);
endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opt_sec_code = 16'h5AA5;
  logic [31:0] opt_wp_mask = '1;
  logic [1:0]  boot_mode = 2'd0;
  logic        dbg_attached = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic        req_opt = 1'b0;
  logic        req_sec_field = 1'b0;
  logic [8:0]  req_page = '0;
  logic [15:0] req_wdata = '0;
  logic        mass_erase_done = 1'b0;
  logic        wperr_clr = 1'b0;
  logic        err_ie = 1'b0;
  logic        req_ready, flash_gnt, req_ack, bus_err, mass_erase_req, wperr, irq;
  logic [1:0]  sec_level;

  int checks = 0;
  int errors = 0;
  logic  exp_wperr = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  flash_guard dut_i (
    .clk(clk), .rst(rst), .opt_sec_code(opt_sec_code), .opt_wp_mask(opt_wp_mask),
    .boot_mode(boot_mode), .dbg_attached(dbg_attached), .req_valid(req_valid),
    .req_op(req_op), .req_opt(req_opt), .req_sec_field(req_sec_field),
    .req_page(req_page), .req_wdata(req_wdata), .req_ready(req_ready),
    .flash_gnt(flash_gnt), .req_ack(req_ack), .bus_err(bus_err),
    .mass_erase_req(mass_erase_req), .mass_erase_done(mass_erase_done),
    .wperr(wperr), .wperr_clr(wperr_clr), .err_ie(err_ie), .irq(irq),
    .sec_level(sec_level));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected {gnt, bus_err, wperr} on each acknowledge
  always @(negedge clk) begin
    if (!rst && req_ack) begin
      if (exp_q.size() == 0) begin
        check("unexpected ack", 1, 0);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {flash_gnt, bus_err, wperr}, e);
      end
    end
  end

  task automatic do_reset(input logic [15:0] code, input logic [31:0] mask);
    @(negedge clk);
    rst = 1'b1;
    opt_sec_code = code;
    opt_wp_mask = mask;
    exp_wperr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // driver: pushes expected outcome then pulses one request
  task automatic issue(input string tag, input logic [1:0] op, input logic opt,
                       input logic secf, input logic [8:0] page, input logic [15:0] wd,
                       input logic gnt, input logic berr, input logic werr);
    @(negedge clk);
    exp_wperr = exp_wperr | werr;
    exp_q.push_back({gnt, berr, exp_wperr});
    tag_q.push_back(tag);
    req_valid = 1'b1; req_op = op; req_opt = opt; req_sec_field = secf;
    req_page = page; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    wperr_clr = 1'b1;
    @(negedge clk);
    wperr_clr = 1'b0;
    exp_wperr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // open level
    do_reset(16'h5AA5, 32'hFFFF_FFFF);
    check("R1 open level", sec_level, 0);
    check("reset outputs", {flash_gnt, req_ack, bus_err, mass_erase_req, wperr}, 0);
    dbg_attached = 1'b1; boot_mode = 2'd1;
    issue("R3 open read in debug", 2'd0, 0, 0, 9'd5, 0, 1, 0, 0);
    issue("R3 open program in sram boot", 2'd1, 0, 0, 9'd200, 0, 1, 0, 0);

    // low level via bad complement
    do_reset(16'h00A5, 32'hFFFF_FFFF);
    check("R1 A5 bad complement is low", sec_level, 1);
    do_reset(16'h1234, 32'hFFFF_FFFF);
    check("R1 other code is low", sec_level, 1);
    opt_sec_code = 16'h00CC; opt_wp_mask = 32'h0;
    repeat (3) @(negedge clk);
    check("R2 level ignores option change", sec_level, 1);
    dbg_attached = 1'b0; boot_mode = 2'd0;
    issue("R2 mask ignores option change", 2'd1, 0, 0, 9'd40, 0, 1, 0, 0);
    boot_mode = 2'd1;
    issue("R4 low read in sram boot", 2'd0, 0, 0, 9'd3, 0, 0, 1, 0);
    err_ie = 1'b1;
    issue("R5 low program in sram boot", 2'd1, 0, 0, 9'd3, 0, 0, 0, 1);
    @(negedge clk);
    check("R7 irq with enable", irq, 1);
    repeat (4) @(negedge clk);
    check("R7 wperr sticky", wperr, 1);
    clear_err();
    check("R7 wperr cleared", wperr, 0);
    check("R7 irq dropped", irq, 0);
    boot_mode = 2'd2;
    issue("R5 low erase in loader boot", 2'd2, 0, 0, 9'd9, 0, 0, 0, 1);
    clear_err();
    boot_mode = 2'd0; dbg_attached = 1'b1;
    issue("R4 low read with debugger", 2'd0, 0, 0, 9'd9, 0, 0, 1, 0);
    issue("R11 option read restricted", 2'd0, 1, 0, 0, 0, 1, 0, 0);
    issue("R11 option program restricted", 2'd1, 1, 0, 0, 16'h1234, 1, 0, 0);
    issue("R11 security write non-open", 2'd1, 1, 1, 0, 16'h00CC, 1, 0, 0);

    // relax sequence
    issue("R9 relax ack after erase", 2'd1, 1, 1, 0, 16'h5AA5, 1, 0, 0);
    check("R9 erase pulse", mass_erase_req, 1);
    check("R9 busy", req_ready, 0);
    check("R9 no early ack", req_ack, 0);
    @(negedge clk);
    check("R9 erase pulse single", mass_erase_req, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 wait no ack", {req_ack, flash_gnt, req_ready}, 0);
    end
    mass_erase_done = 1'b1;
    @(negedge clk);
    mass_erase_done = 1'b0;
    @(negedge clk);
    check("R9 ready after done", req_ready, 1);
    check("R9 level held until reset", sec_level, 1);

    // high level
    dbg_attached = 1'b0; boot_mode = 2'd0;
    do_reset(16'h00CC, 32'hFFFF_FFFF);
    check("R1 high level", sec_level, 2);
    issue("R10 high user read", 2'd0, 0, 0, 9'd1, 0, 1, 0, 0);
    issue("R10 security field locked", 2'd1, 1, 1, 0, 16'h5AA5, 0, 0, 1);
    clear_err();
    dbg_attached = 1'b1;
    issue("R10 high debug main read", 2'd0, 0, 0, 9'd1, 0, 0, 1, 0);
    issue("R10 high debug option read", 2'd0, 1, 0, 0, 0, 0, 1, 0);
    issue("R10 high debug option program", 2'd1, 1, 0, 0, 16'h1, 0, 0, 1);
    clear_err();

    // write protection
    dbg_attached = 1'b0;
    do_reset(16'h5AA5, 32'hFFFF_FFFD);
    err_ie = 1'b0;
    issue("R6 region1 page16 protected", 2'd1, 0, 0, 9'd16, 0, 0, 0, 1);
    @(negedge clk);
    check("R7 irq masked", irq, 0);
    clear_err();
    issue("R6 region0 page15 open", 2'd1, 0, 0, 9'd15, 0, 1, 0, 0);
    issue("R6 region1 page31 erase protected", 2'd2, 0, 0, 9'd31, 0, 0, 0, 1);
    clear_err();
    issue("R6 region2 page32 open", 2'd2, 0, 0, 9'd32, 0, 1, 0, 0);
    issue("R6 protected read allowed", 2'd0, 0, 0, 9'd16, 0, 1, 0, 0);
    issue("R8 option erase granted", 2'd2, 1, 0, 0, 0, 1, 0, 0);
    issue("R8 protection removed", 2'd1, 0, 0, 9'd16, 0, 1, 0, 0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule